// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block lets an external bus master read and write a bank of 8-bit registers over a two-wire serial link made of a clock line and a data line. The block is a slave only. Both bus lines arrive as plain inputs and are oversampled by the block's own system clock, which runs at least four times faster than the serial clock. The serial clock never clocks any flop. The block drives the data line through an open-drain control output: when that output is high, the board pulls the line low, and otherwise the line is released.

A transfer opens with a start condition. The master then sends a device address byte, made of a 7-bit address and a direction bit. A write continues with a register address byte and then one data byte; each byte is acknowledged, and a one-cycle write strobe goes to the register file. A read first sets the register address in the same way. The master then sends a repeated start and the device address with the direction bit set. The slave answers with the addressed register's 8 bits, and the master closes with a not-acknowledge and a stop.

A strap input picks which of two fixed 7-bit device addresses the block answers to. The strap is captured only while reset is asserted.

Top module: `sbus_reg_slave`

## Requirements
- R1: While reset is asserted and immediately after it, the data-line pull-down output is low and the write strobe is low.
- R2: With the strap captured low, a device address byte whose upper 7 bits are 1010101 is acknowledged.
- R3: With the strap captured high, the address 0110011 is acknowledged and 1010101 is not. A strap change after reset has no effect until the next reset.
- R4: A device address byte that does not match gets no acknowledge. Every later byte up to the next start or stop is neither acknowledged nor written.
- R5: A write sequence (address with direction bit 0, register address, data) acknowledges all three bytes. It then produces a write strobe carrying that register address and data, after the acknowledge of the data byte.
- R6: A read sequence (address with direction bit 0, register address, repeated start, address with direction bit 1) acknowledges every address byte. The slave then returns the addressed register's 8 bits, most significant bit first.
- R7: An acknowledge holds the data line low for the whole high phase of the ninth clock. The slave changes the line only while the serial clock is low, so every returned data bit stays constant while the clock is high.
- R8: A stop condition part-way through a data byte aborts the transfer without any register write. It also releases the data line.
- R9: During the master's not-acknowledge after read data the slave releases the line, and it stays released after the stop.
- R10: Each completed write produces a write strobe exactly one system-clock cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is clocked on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; strap captured while low |
| addr_sel | input | 1 | Device address strap (low: 1010101, high: 0110011) |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_pull_lo | output | 1 | High pulls the open-drain data line low |
| reg_addr | output | 8 | Register address latched from the bus |
| reg_wdata | output | 8 | Write data for the register file |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_rdata | input | 8 | Read data for the register at reg_addr |

## Verification
The embedded properties check on every cycle that the pull-down output moves only while the synchronized serial clock is low and is asserted only inside an active transfer. They also check that a stop returns the block to idle with the line released, and that the write strobe is a single cycle that follows a data-byte acknowledge. Address matching against the strap, strap capture only at reset, the MSB-first order of returned data, and the absence of writes after a mismatch or an aborted byte depend on whole bus sequences. Only the bench's write and read transactions can show those.

// File: rtl/sbus_reg_slave.sv
module sbus_reg_slave #(
  parameter logic [6:0] DEV_ID_LO = 7'b1010101,
  parameter logic [6:0] DEV_ID_HI = 7'b0110011
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_sel,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_lo,
  output logic [7:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_we,
  input  logic [7:0] reg_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_DEV, S_REG, S_WDAT, S_RDAT, S_SKIP} st_t;

  st_t        state;
  logic [2:0] scl_q, sda_q;
  logic [3:0] cnt;
  logic [7:0] shreg, txreg;
  logic       sel_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
    end

  wire       scl_hi   = scl_q[1] & scl_q[2];
  wire       scl_rise = scl_q[1] & ~scl_q[2];
  wire       scl_fall = ~scl_q[1] & scl_q[2];
  wire       start_c  = scl_hi & sda_q[2] & ~sda_q[1];
  wire       stop_c   = scl_hi & ~sda_q[2] & sda_q[1];
  wire [6:0] my_id    = sel_q ? DEV_ID_HI : DEV_ID_LO;
  wire       active   = (state != S_IDLE) && (state != S_SKIP);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      shreg       <= '0;
      txreg       <= '0;
      sda_pull_lo <= 1'b0;
      sel_q       <= addr_sel;
      reg_addr    <= '0;
      reg_wdata   <= '0;
      reg_we      <= 1'b0;
    end else begin
      reg_we <= 1'b0;
      if (start_c) begin
        state       <= S_DEV;
        cnt         <= '0;
        sda_pull_lo <= 1'b0;
      end else if (stop_c) begin
        state       <= S_IDLE;
        cnt         <= '0;
        sda_pull_lo <= 1'b0;
      end else if (active) begin
        if (scl_rise) begin
          if (cnt < 4'd8) shreg <= {shreg[6:0], sda_q[1]};
          cnt <= cnt + 4'd1;
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            if (state == S_RDAT)                               sda_pull_lo <= 1'b0;
            else if (state == S_DEV && shreg[7:1] != my_id)    state <= S_SKIP;
            else                                               sda_pull_lo <= 1'b1;
          end else if (cnt == 4'd9) begin
            cnt         <= '0;
            sda_pull_lo <= 1'b0;
            case (state)
              S_DEV:
                if (shreg[0]) begin
                  state       <= S_RDAT;
                  txreg       <= reg_rdata;
                  sda_pull_lo <= ~reg_rdata[7];
                end else state <= S_REG;
              S_REG: begin
                reg_addr <= shreg;
                state    <= S_WDAT;
              end
              S_WDAT: begin
                reg_wdata <= shreg;
                reg_we    <= 1'b1;
                state     <= S_SKIP;
              end
              default: state <= S_SKIP;
            endcase
          end else if (state == S_RDAT) begin
            txreg       <= {txreg[6:0], 1'b0};
            sda_pull_lo <= ~txreg[6];
          end
        end
      end
    end

  // R7
  pull_chg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_lo != $past(sda_pull_lo)) && !$past(start_c | stop_c) |-> !scl_q[1]);

  // R4
  pull_when_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull_lo |-> (state != S_IDLE && state != S_SKIP));

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> (state == S_IDLE && !sda_pull_lo));

  // R10
  we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R5
  we_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> ($past(state) == S_WDAT && $past(scl_fall)));
endmodule

// File: tb/sbus_reg_slave_tb.sv
module sbus_reg_slave_tb_top;
  localparam int Q = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_sel = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_pull_lo, reg_we;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic [7:0] mem [256];
  logic [255:0] written = '0;
  int         wr_cnt = 0, wide_we = 0;
  logic       we_prev = 1'b0;
  logic [7:0] last_a = '0, last_d = '0;
  int         checks = 0, fails = 0;
  logic [7:0] shadow [256];
  bit         done = 0;

  wire sda_line = sda_m & ~sda_pull_lo;

  always #10 clk = ~clk;

  sbus_reg_slave dut_i (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_lo(sda_pull_lo), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = written[reg_addr] ? mem[reg_addr] : (reg_addr ^ 8'h5A);

  always @(posedge clk) begin
    we_prev <= reg_we;
    if (reg_we && we_prev) wide_we <= wide_we + 1;
    if (reg_we) begin
      mem[reg_addr]     <= reg_wdata;
      written[reg_addr] <= 1'b1;
      wr_cnt            <= wr_cnt + 1;
      last_a            <= reg_addr;
      last_d            <= reg_wdata;
    end
  end

  // {rd, dev[6:0], reg[7:0], data[7:0], hit}
  localparam logic [24:0] VEC [9] = '{
    {1'b0, 7'h55, 8'h10, 8'hA5, 1'b1},
    {1'b0, 7'h55, 8'hFF, 8'h3C, 1'b1},
    {1'b1, 7'h55, 8'h10, 8'h00, 1'b1},
    {1'b1, 7'h55, 8'hFF, 8'h00, 1'b1},
    {1'b0, 7'h33, 8'h20, 8'h77, 1'b0},
    {1'b1, 7'h55, 8'h20, 8'h00, 1'b1},
    {1'b1, 7'h55, 8'h00, 8'h00, 1'b1},
    {1'b0, 7'h55, 8'h00, 8'h01, 1'b1},
    {1'b1, 7'h55, 8'h00, 8'h00, 1'b1}
  };

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start;
    scl = 1'b0; tick(Q);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic do_stop;
    scl = 1'b0; sda_m = 1'b0; tick(Q);
    scl = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2 * Q);
  endtask

  task automatic send_bit(bit b);
    sda_m = b; tick(Q);
    scl = 1'b1; tick(2 * Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output bit acked, output bit nacked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;
    acked = 1; nacked = 1;
    for (int k = 0; k < 2 * Q; k++) begin
      tick(1);
      if (sda_line) acked = 0; else nacked = 0;
    end
    scl = 1'b0; tick(Q);
  endtask

  task automatic read_byte(output logic [7:0] d, output bit steady, output bit released);
    steady = 1;
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q);
      scl = 1'b1; tick(1);
      d[i] = sda_line;
      for (int k = 1; k < 2 * Q; k++) begin
        tick(1);
        if (sda_line != d[i]) steady = 0;
      end
      scl = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl = 1'b1; tick(Q);
    released = sda_line && !sda_pull_lo;
    tick(Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic write_txn(logic [6:0] dev, logic [7:0] ra, logic [7:0] dt,
                           output bit all_ack, output bit all_nack);
    bit a, n;
    do_start;
    send_byte({dev, 1'b0}, a, n); all_ack = a; all_nack = n;
    send_byte(ra, a, n);          all_ack &= a; all_nack &= n;
    send_byte(dt, a, n);          all_ack &= a; all_nack &= n;
    do_stop;
  endtask

  task automatic read_txn(logic [6:0] dev, logic [7:0] ra, output logic [7:0] d,
                          output bit all_ack, output bit steady, output bit released);
    bit a, n;
    do_start;
    send_byte({dev, 1'b0}, a, n); all_ack = a;
    send_byte(ra, a, n);          all_ack &= a;
    do_start;
    send_byte({dev, 1'b1}, a, n); all_ack &= a;
    read_byte(d, steady, released);
    do_stop;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; tick(3);
    rst_n = 1'b1; tick(3);
  endtask

  initial begin
    logic [7:0] d;
    bit ack, nack, st, rel;
    int w0;
    for (int i = 0; i < 256; i++) shadow[i] = 8'(i) ^ 8'h5A;
    tick(2);
    // R1
    check(sda_pull_lo == 1'b0 && reg_we == 1'b0, "R1 in reset", {sda_pull_lo, reg_we}, 0);
    do_reset;
    check(sda_pull_lo == 1'b0 && reg_we == 1'b0, "R1 after reset", {sda_pull_lo, reg_we}, 0);

    for (int v = 0; v < 9; v++) begin
      logic [24:0] e;
      e = VEC[v];
      if (!e[24]) begin
        w0 = wr_cnt;
        write_txn(e[23:17], e[16:9], e[8:1], ack, nack);
        tick(2);
        if (e[0]) begin
          // R2 R5
          check(ack, "R2/R5 write acks", ack, 1);
          check(wr_cnt == w0 + 1 && last_a == e[16:9] && last_d == e[8:1], "R5 write strobe",
                {last_a, last_d}, {e[16:9], e[8:1]});
          shadow[e[16:9]] = e[8:1];
        end else begin
          // R4
          check(nack, "R4 mismatch nack", nack, 1);
          check(wr_cnt == w0, "R4 no write", wr_cnt - w0, 0);
        end
      end else begin
        read_txn(e[23:17], e[16:9], d, ack, st, rel);
        // R6 R7 R9
        check(ack, "R6 read acks", ack, 1);
        check(d == shadow[e[16:9]], "R6 read data", d, shadow[e[16:9]]);
        check(st, "R7 bits steady while clock high", st, 1);
        check(rel, "R9 released at master nack", rel, 1);
        check(sda_pull_lo == 1'b0, "R9 released after stop", sda_pull_lo, 0);
      end
    end

    // R8: stop mid data byte
    w0 = wr_cnt;
    do_start;
    send_byte({7'h55, 1'b0}, ack, nack);
    send_byte(8'h40, ack, nack);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    do_stop;
    tick(2);
    check(wr_cnt == w0, "R8 aborted byte not written", wr_cnt - w0, 0);
    check(sda_pull_lo == 1'b0, "R8 line released", sda_pull_lo, 0);
    read_txn(7'h55, 8'h40, d, ack, st, rel);
    check(d == shadow[8'h40], "R8 register unchanged", d, shadow[8'h40]);

    // R10
    check(wide_we == 0, "R10 strobe width", wide_we, 0);

    // R3: strap change without reset has no effect
    addr_sel = 1'b1;
    tick(4);
    do_start;
    send_byte({7'h55, 1'b0}, ack, nack);
    do_stop;
    check(ack, "R3 strap not resampled", ack, 1);
    do_reset;
    do_start;
    send_byte({7'h55, 1'b0}, ack, nack);
    do_stop;
    check(nack, "R3 old address refused", nack, 1);
    w0 = wr_cnt;
    write_txn(7'h33, 8'h05, 8'hE1, ack, nack);
    tick(2);
    check(ack && wr_cnt == w0 + 1 && last_d == 8'hE1, "R3 high strap address write",
          {ack, last_d}, {1'b1, 8'hE1});
    shadow[8'h05] = 8'hE1;
    read_txn(7'h33, 8'h05, d, ack, st, rel);
    check(ack && d == 8'hE1, "R3 high strap address read", d, 8'hE1);
    check(wide_we == 0, "R10 strobe width final", wide_we, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule